// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block collects three interrupt sources for a small 8-bit core and presents them through one 8-bit control register. The sources are an external pin with a programmable trigger edge, a one-cycle overflow pulse from an 8-bit timer, and a mismatch detector on a four-pin port group. Each source has a sticky flag and its own enable bit. A global enable gates the interrupt request to the core. When the core accepts the interrupt it pulses an acknowledge, and the block then clears the global enable by itself.

A small power-mode state machine handles sleep. It has three states. **ST_RUN** is normal operation. **ST_SLEEP** is the core sleeping. **ST_WAKE** means a wake-up request is being held. The transitions are:
- **go_sleep** (ST_RUN to ST_SLEEP) fires when the sleep input rises. It takes a snapshot of the three individual enables.
- **wake_hit** (ST_SLEEP to ST_WAKE) fires when any flag is set whose enable was in the snapshot. The global enable plays no part in this.
- **sleep_abort** (ST_SLEEP to ST_RUN) fires when sleep drops with no wake.
- **wake_done** (ST_WAKE to ST_RUN) fires when the core drops sleep.

After wake-up, the global enable alone decides whether the core also receives an interrupt request. The external pin and the port pins are resynchronised through a two-flop chain before any detection.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, ctl_rdata reads 0x00, and irq_req and wake are 0.
- R2: Control bits 3 (port enable), 4 (external enable), 5 (timer enable), 6 (peripheral enable, plain storage) and 7 (global enable) read back exactly as last written via wr_en/wr_data.
- R3: A one-cycle tmr_ovf pulse sets bit 2 (timer flag), which is visible on ctl_rdata after the next clock edge.
- R4: With edge_rise=1 a rising edge of ext_pin sets bit 1 (external flag); with edge_rise=0 a falling edge does; the opposite edge has no effect. The flag appears at most four clock edges after the pin changes.
- R5: Flags in bits 0 to 2 stay set until software writes a 0 to them.
- R6: A hardware flag set in the same cycle as a software write of 0 to that flag leaves the flag set.
- R7: Bit 0 (port flag) is set while the synchronised port_pins differ from an internal latch. Writing 0 to the flag does not clear the condition. A port_rd pulse copies the synchronised pins into the latch, after which the flag can be cleared.
- R8: irq_req is 1 exactly when bit 7 is 1 and some flag bit n (n = 0..2) is set together with its enable bit n+3.
- R9: An irq_ack pulse clears bit 7 at the next edge, even if a write in the same cycle sets it.
- R10: In sleep, a set flag whose enable was 1 when sleep was entered drives wake to 1 regardless of bit 7, and wake stays 1 until sleep drops.
- R11: A flag set during sleep whose enable was 0 at sleep entry does not assert wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| edge_rise | input | 1 | 1 selects rising edge, 0 selects falling edge |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle |
| port_pins | input | 4 | Asynchronous port pins watched for change |
| port_rd | input | 1 | Port read strobe, reloads the compare latch |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| irq_ack | input | 1 | Core accepted the interrupt |
| sleep | input | 1 | Core is sleeping |
| ctl_rdata | output | 8 | Control register readback |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up request to the core |

## Verification
A corrupted flag or enable shows up on ctl_rdata one edge after the event that caused it. Because irq_req is combinational on that register, the same cycle also shows a wrong request. Errors in the synchroniser or the edge history appear as a flag that comes early, late, or on the wrong polarity, within four edges of the pin change. A snapshot or state machine fault shows up in sleep as a missing or spurious wake, or as a wake that persists after sleep drops, within two edges.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int CTL_W     = 8;
    localparam int SRC_N     = 3;
    localparam int B_PFLAG   = 0;
    localparam int B_XFLAG   = 1;
    localparam int B_TFLAG   = 2;
    localparam int B_EN_LO   = 3;
    localparam int B_GIE     = 7;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_s,
    input  logic              edge_rise,
    input  logic [PORT_W-1:0] port_s,
    input  logic              port_rd,
    output logic              ext_hit,
    output logic              port_mismatch
);
    logic              ext_prev;
    logic [PORT_W-1:0] port_latch;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev   <= 1'b0;
            port_latch <= '0;
        end else begin
            ext_prev <= ext_s;
            if (port_rd) port_latch <= port_s;
        end
    end

    always_comb begin
        if (edge_rise) ext_hit = ext_s & ~ext_prev;
        else           ext_hit = ~ext_s & ext_prev;
        port_mismatch = (port_s != port_latch);
    end

    // R7: after a port read the latch holds the pins seen in that cycle
    a_r7_latch_reload: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> (port_latch == $past(port_s)));
endmodule

// File: rtl/irq_pwr_fsm.sv
module irq_pwr_fsm
    import irq_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep,
    input  logic [N-1:0] en_now,
    input  logic [N-1:0] flags,
    output logic         wake
);
    pwr_state_t   state_q, state_d;
    logic [N-1:0] en_snap;
    logic         pending;

    assign pending = |(flags & en_snap);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (sleep)        state_d = ST_SLEEP;   // go_sleep
            ST_SLEEP: if (!sleep)       state_d = ST_RUN;     // sleep_abort
                      else if (pending) state_d = ST_WAKE;    // wake_hit
            ST_WAKE:  if (!sleep)       state_d = ST_RUN;     // wake_done
            default:                    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            en_snap <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && sleep) en_snap <= en_now;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_WAKE: wake = 1'b1;
            default: wake = 1'b0;
        endcase
    end

    // R10: wake holds while sleep stays high
    a_r10_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && sleep) |=> wake);
    // R10: wake is released once sleep drops
    a_r10_wake_release: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> !wake);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int PORT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              edge_rise,
    input  logic              tmr_ovf,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              port_rd,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic              irq_ack,
    input  logic              sleep,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic              irq_req,
    output logic              wake
);
    localparam int SW = PORT_W + 1;

    logic [CTL_W-1:0]  ctl_q, ctl_d;
    logic [SW-1:0]     sync_out;
    logic              ext_s, ext_hit, port_mismatch;
    logic [PORT_W-1:0] port_s;
    logic [SRC_N-1:0]  hw_set, flags, ens;

    irq_sync #(.W(SW), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d_async({port_pins, ext_pin}),
        .d_sync(sync_out)
    );
    assign ext_s  = sync_out[0];
    assign port_s = sync_out[SW-1:1];

    irq_src_detect #(.PORT_W(PORT_W)) det_i (
        .clk(clk), .rst_n(rst_n),
        .ext_s(ext_s), .edge_rise(edge_rise),
        .port_s(port_s), .port_rd(port_rd),
        .ext_hit(ext_hit), .port_mismatch(port_mismatch)
    );

    assign hw_set = {tmr_ovf, ext_hit, port_mismatch};
    assign flags  = ctl_q[B_TFLAG:B_PFLAG];
    assign ens    = ctl_q[B_EN_LO+SRC_N-1:B_EN_LO];

    always_comb begin
        ctl_d = wr_en ? wr_data : ctl_q;
        ctl_d[B_TFLAG:B_PFLAG] = ctl_d[B_TFLAG:B_PFLAG] | hw_set;
        if (irq_ack) ctl_d[B_GIE] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_rdata = ctl_q;
    assign irq_req   = ctl_q[B_GIE] & |(flags & ens);

    irq_pwr_fsm #(.N(SRC_N)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .en_now(ens), .flags(flags), .wake(wake)
    );

    // R5: a set flag survives any cycle without a register write
    a_r5_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_XFLAG] && !wr_en) |=> ctl_q[B_XFLAG]);
    // R6: timer pulse wins over a same-cycle clearing write
    a_r6_tmr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> ctl_q[B_TFLAG]);
    // R9: acknowledge always drops the global enable
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !ctl_q[B_GIE]);
    // R7: an outstanding mismatch without a port read re-sets the port flag
    a_r7_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        port_mismatch |=> ctl_q[B_PFLAG]);
endmodule

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0, edge_rise = 1'b1, tmr_ovf = 1'b0;
    logic [3:0] port_pins = 4'h0;
    logic       port_rd = 1'b0, wr_en = 1'b0, irq_ack = 1'b0, sleep = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctl_rdata;
    logic       irq_req, wake;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    irq_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rise(edge_rise),
        .tmr_ovf(tmr_ovf), .port_pins(port_pins), .port_rd(port_rd),
        .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack), .sleep(sleep),
        .ctl_rdata(ctl_rdata), .irq_req(irq_req), .wake(wake)
    );

    // {wr_en, wr_data, tmr_ovf, exp_rdata, exp_irq}
    localparam logic [18:0] VEC [0:7] = '{
        {1'b1, 8'h00, 1'b0, 8'h00, 1'b0},   // R2 clear all
        {1'b1, 8'h20, 1'b0, 8'h20, 1'b0},   // R2 timer enable
        {1'b0, 8'h00, 1'b1, 8'h24, 1'b0},   // R3 overflow, no global enable
        {1'b1, 8'hA4, 1'b0, 8'hA4, 1'b1},   // R8 request
        {1'b1, 8'hA0, 1'b0, 8'hA0, 1'b0},   // R5 software clear
        {1'b1, 8'hA0, 1'b1, 8'hA4, 1'b1},   // R6 hardware wins
        {1'b1, 8'h84, 1'b0, 8'h84, 1'b0},   // R8 masked by enable
        {1'b1, 8'h40, 1'b0, 8'h40, 1'b0}    // R2 peripheral bit storage
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 rdata", ctl_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq_req}, 8'h00);
        chk("R1 wake", {7'd0, wake}, 8'h00);

        for (int v = 0; v < 8; v++) begin
            wr_en = VEC[v][18]; wr_data = VEC[v][17:10]; tmr_ovf = VEC[v][9];
            cyc(1);
            wr_en = 1'b0; tmr_ovf = 1'b0;
            chk("R2/R3/R5/R6/R8 vec rdata", ctl_rdata, VEC[v][8:1]);
            chk("R8 vec irq", {7'd0, irq_req}, {7'd0, VEC[v][0]});
        end

        // R4 rising edge
        wr(8'h90); edge_rise = 1'b1; ext_pin = 1'b1; cyc(4);
        chk("R4 rising sets", ctl_rdata, 8'h92);
        chk("R8 ext irq", {7'd0, irq_req}, 8'h01);
        wr(8'h90); ext_pin = 1'b0; cyc(4);
        chk("R4 falling ignored", ctl_rdata, 8'h90);
        edge_rise = 1'b0; ext_pin = 1'b1; cyc(4);
        chk("R4 rise ignored in falling mode", ctl_rdata, 8'h90);
        ext_pin = 1'b0; cyc(4);
        chk("R4 falling sets", ctl_rdata, 8'h92);
        // R9 ack beats a setting write
        wr_en = 1'b1; wr_data = 8'h92; irq_ack = 1'b1; cyc(1);
        wr_en = 1'b0; irq_ack = 1'b0;
        chk("R9 ack clears", ctl_rdata, 8'h12);
        chk("R9 irq low", {7'd0, irq_req}, 8'h00);

        // R7 port change
        wr(8'h08); port_pins = 4'hA; cyc(4);
        chk("R7 change sets", ctl_rdata, 8'h09);
        wr(8'h08); cyc(1);
        chk("R7 re-set before read", ctl_rdata, 8'h09);
        port_rd = 1'b1; cyc(1); port_rd = 1'b0;
        wr(8'h08); cyc(2);
        chk("R7 cleared after read", ctl_rdata, 8'h08);

        // R11 masked source does not wake
        edge_rise = 1'b1;
        wr(8'h00); sleep = 1'b1; cyc(2);
        tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0; cyc(3);
        chk("R11 no wake", {7'd0, wake}, 8'h00);
        chk("R11 flag set", ctl_rdata, 8'h04);
        sleep = 1'b0; cyc(2);

        // R10 enabled external wakes without global enable
        wr(8'h10); sleep = 1'b1; cyc(2);
        chk("R10 idle sleep", {7'd0, wake}, 8'h00);
        ext_pin = 1'b1; cyc(6);
        chk("R10 wake", {7'd0, wake}, 8'h01);
        chk("R10 no irq without global", {7'd0, irq_req}, 8'h00);
        cyc(2);
        chk("R10 wake held", {7'd0, wake}, 8'h01);
        sleep = 1'b0; cyc(2);
        chk("R10 wake released", {7'd0, wake}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule